// File: doc/BRIEF.md
# I2C configuration register slave

This block is a serial-bus target that gives a host read and write access to a 256-location byte address space. The bus lines are oversampled on the system clock, so the block is a fully synchronous piece of logic with no clock taken from the bus. Only two address windows are backed by storage, 08H to 1BH and 40H to 57H. All other locations are accepted by the protocol, read back as zero and drop writes.

A host writes by sending the device address with the direction bit clear, then a register address, then any number of data bytes. The block keeps an internal pointer that advances after every byte written or read and that survives between transactions. This allows current-address reads, random reads (set the pointer, then issue a repeated START) and sequential reads. The stored bytes of both windows are driven out in parallel, so the rest of the chip sees each new value as soon as the block acknowledges it.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The block responds only to the 7-bit device address 69H, which is carried in bits 7:1 of the first byte after a START, with bit 0 as the direction (1 = read). For any other address it leaves SDA released for the rest of that frame and changes no register.
- R2: The block acknowledges by holding SDA low during the 9th SCL pulse of the matched device-address byte, of the register-address byte and of every write data byte.
- R3: In a write burst, successive data bytes go to successive register addresses, starting at the register address sent, until a STOP.
- R4: A written byte appears on the parallel window outputs before the rising SCL edge of its acknowledge pulse.
- R5: A read that does not first set the pointer returns location n+1, where n is the last location written or read, even across transactions.
- R6: A repeated START after the register-address byte loads the pointer, stores no data, and the read that follows starts at that address.
- R7: During a read, a master ACK (SDA low on the 9th pulse) makes the block send the next location. A master NACK ends the transfer, and the block keeps SDA released afterwards.
- R8: The pointer wraps from FFH to 00H, for both writes and reads.
- R9: Only 08H–1BH and 40H–57H hold storage. Other locations read 00H and ignore writes, but the data bytes are still acknowledged.
- R10: After reset every stored byte is 00H and SDA is released.
- R11: A STOP (SDA rising while SCL is high) that arrives before a data byte is complete discards that byte. A START (SDA falling while SCL is high) restarts device-address reception in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_drive_low_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| win0_o | output | 160 | Bytes 08H..1BH, byte k of the window at bits 8k+7:8k |
| win1_o | output | 192 | Bytes 40H..57H, byte k of the window at bits 8k+7:8k |

## Verification
Two functions can act in the same cycle. On the SCL fall that ends a write data byte, the block stores the byte and advances the pointer together. When that byte sits at FFH, the store lands in no window and the pointer wraps in that same cycle. The bench provokes this with bursts that cross FFH and the end of each window, then reads sequentially across the wrap. A reference model holds its own pointer and byte array. It compares both parallel windows with the model on every clock and compares every read byte with the model value at the model pointer, so a wrong store or a wrong pointer step shows up as a mismatch.

// File: rtl/cfg_i2c_pkg.sv
// Shared types for the serial configuration target.
// Assumes: one frame in progress at a time; the state encoding is local to this block.
package cfg_i2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } sl_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes SCL and SDA into the clk domain and derives edge and frame events.
// Assumes: both lines idle high; the events are single-cycle pulses, delayed by
// STAGES + 1 clocks from the pins.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_s
);

    logic [STAGES:0] scl_p;
    logic [STAGES:0] sda_p;
    logic scl_now, scl_old, sda_old;

    // Shift both lines through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[STAGES-1:0], scl_i};
            sda_p <= {sda_p[STAGES-1:0], sda_i};
        end
    end

    // Edge and frame-event decode on the synchronized lines.
    always_comb begin
        scl_now   = scl_p[STAGES-1];
        scl_old   = scl_p[STAGES];
        sda_s     = sda_p[STAGES-1];
        sda_old   = sda_p[STAGES];
        scl_rise  = scl_now & ~scl_old;
        scl_fall  = ~scl_now & scl_old;
        start_det = scl_now & scl_old & sda_old & ~sda_s;
        stop_det  = scl_now & scl_old & ~sda_old & sda_s;
    end

endmodule

// File: rtl/cfg_win_regs.sv
// Byte storage for two address windows of a 256-location space, with a
// combinational read port and parallel outputs.
// Assumes: the windows do not overlap; a write outside both windows is dropped.
module cfg_win_regs #(
    parameter logic [7:0] WIN0_BASE = 8'h08,
    parameter int         WIN0_LEN  = 20,
    parameter logic [7:0] WIN1_BASE = 8'h40,
    parameter int         WIN1_LEN  = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            addr,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata,
    output logic [WIN0_LEN*8-1:0] win0_o,
    output logic [WIN1_LEN*8-1:0] win1_o
);

    localparam int         W0_AW  = $clog2(WIN0_LEN);
    localparam int         W1_AW  = $clog2(WIN1_LEN);
    localparam logic [8:0] W0_END = 9'(WIN0_BASE) + 9'(WIN0_LEN);
    localparam logic [8:0] W1_END = 9'(WIN1_BASE) + 9'(WIN1_LEN);

    logic [7:0]       w0 [WIN0_LEN];
    logic [7:0]       w1 [WIN1_LEN];
    logic             in0, in1;
    logic [7:0]       off0, off1;
    logic [W0_AW-1:0] idx0;
    logic [W1_AW-1:0] idx1;

    // Window hit decode and local offsets.
    always_comb begin
        in0   = ({1'b0, addr} >= {1'b0, WIN0_BASE}) && ({1'b0, addr} < W0_END);
        in1   = ({1'b0, addr} >= {1'b0, WIN1_BASE}) && ({1'b0, addr} < W1_END);
        off0  = addr - WIN0_BASE;
        off1  = addr - WIN1_BASE;
        idx0  = off0[W0_AW-1:0];
        idx1  = off1[W1_AW-1:0];
        rdata = in0 ? w0[idx0] : (in1 ? w1[idx1] : 8'h00);
    end

    // Clear to the blank state, then store bytes that hit a window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN0_LEN; i++) w0[i] <= 8'h00;
            for (int i = 0; i < WIN1_LEN; i++) w1[i] <= 8'h00;
        end else if (wr_en) begin
            if (in0) w0[idx0] <= wdata;
            if (in1) w1[idx1] <= wdata;
        end
    end

    // Flatten both windows onto the parallel outputs.
    for (genvar g = 0; g < WIN0_LEN; g++) begin : g_w0
        assign win0_o[g*8 +: 8] = w0[g];
    end
    for (genvar g = 0; g < WIN1_LEN; g++) begin : g_w1
        assign win1_o[g*8 +: 8] = w1[g];
    end

    // R9
    miss_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in0 && !in1) |=> ($stable(win0_o) && $stable(win1_o)));

endmodule

// File: rtl/cfg_i2c_slave.sv
// Serial-bus target with an auto-incrementing pointer into a windowed byte
// register space; stored bytes are exposed in parallel.
// Assumes: the bus is slow against clk (an SCL half period spans several clocks);
// no clock stretching; 7-bit addressing only.
module cfg_i2c_slave #(
    parameter logic [6:0] DEV_ADDR  = 7'h69,
    parameter int         SYNC_STG  = 2,
    parameter logic [7:0] WIN0_BASE = 8'h08,
    parameter int         WIN0_LEN  = 20,
    parameter logic [7:0] WIN1_BASE = 8'h40,
    parameter int         WIN1_LEN  = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_drive_low_o,
    output logic [WIN0_LEN*8-1:0] win0_o,
    output logic [WIN1_LEN*8-1:0] win1_o
);
    import cfg_i2c_pkg::*;

    localparam int BYTE_BITS = 8;
    localparam int CNT_W     = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_BITS - 1);

    sl_state_t  state;
    logic [CNT_W-1:0] bit_cnt;
    logic [7:0] rx_byte, tx_byte, ptr, rd_data;
    logic       rw_bit, m_ack, sda_oe;
    logic       scl_rise, scl_fall, start_det, stop_det, sda_s;
    logic       wr_stb, byte_in_done;

    i2c_line_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s)
    );

    cfg_win_regs #(
        .WIN0_BASE(WIN0_BASE), .WIN0_LEN(WIN0_LEN),
        .WIN1_BASE(WIN1_BASE), .WIN1_LEN(WIN1_LEN)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_stb), .addr(ptr),
        .wdata(rx_byte), .rdata(rd_data), .win0_o(win0_o), .win1_o(win1_o)
    );

    // A received byte is complete on the SCL fall after its 8th bit.
    always_comb begin
        byte_in_done = scl_fall && (bit_cnt == CNT_FULL) && !start_det && !stop_det;
        wr_stb       = (state == ST_WR) && byte_in_done;
    end

    // Frame state machine: receive, acknowledge, transmit and pointer handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            rx_byte <= 8'h00;
            tx_byte <= 8'h00;
            ptr     <= 8'h00;
            rw_bit  <= 1'b0;
            m_ack   <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (start_det) begin
            state   <= ST_DEV;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            sda_oe  <= 1'b0;
        end else begin
            case (state)
                ST_DEV, ST_REG, ST_WR: begin
                    if (scl_rise && bit_cnt != CNT_FULL) begin
                        rx_byte <= {rx_byte[6:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_in_done) begin
                        bit_cnt <= '0;
                        if (state == ST_DEV) begin
                            if (rx_byte[7:1] == DEV_ADDR) begin
                                sda_oe <= 1'b1;
                                rw_bit <= rx_byte[0];
                                state  <= ST_DEV_ACK;
                            end else begin
                                state  <= ST_IDLE;
                            end
                        end else if (state == ST_REG) begin
                            ptr    <= rx_byte;
                            sda_oe <= 1'b1;
                            state  <= ST_REG_ACK;
                        end else begin
                            ptr    <= ptr + 8'd1;
                            sda_oe <= 1'b1;
                            state  <= ST_WR_ACK;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        if (rw_bit) begin
                            tx_byte <= rd_data;
                            sda_oe  <= ~rd_data[7];
                            bit_cnt <= '0;
                            state   <= ST_RD;
                        end else begin
                            sda_oe  <= 1'b0;
                            state   <= ST_REG;
                        end
                    end
                end
                ST_REG_ACK, ST_WR_ACK: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_WR;
                    end
                end
                ST_RD: begin
                    if (scl_fall) begin
                        if (bit_cnt == CNT_LAST) begin
                            sda_oe <= 1'b0;
                            ptr    <= ptr + 8'd1;
                            state  <= ST_RD_ACK;
                        end else begin
                            tx_byte <= {tx_byte[6:0], 1'b0};
                            sda_oe  <= ~tx_byte[6];
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        m_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (m_ack) begin
                            tx_byte <= rd_data;
                            sda_oe  <= ~rd_data[7];
                            bit_cnt <= '0;
                            state   <= ST_RD;
                        end else begin
                            state   <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sda_drive_low_o = sda_oe;

    // R1
    dev_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV_ACK) |-> (rx_byte[7:1] == DEV_ADDR));

    // R2
    rx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV || state == ST_REG || state == ST_WR) |-> !sda_oe);

    // R10
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R8
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && ptr == 8'hFF) |=> (ptr == 8'h00));

    // R5
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD && scl_fall && bit_cnt == CNT_LAST)
        |=> (ptr == $past(ptr) + 8'd1));

endmodule

// File: tb/cfg_i2c_slave_tb.sv
// Bench: behavioural bus master plus a reference model (byte array and pointer)
// compared with the parallel windows on every clock and with every read byte.
module cfg_i2c_slave_tb;

    localparam int HALF = 10;
    localparam logic [6:0] DEV = 7'h69;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic drv;
    logic sda_bus;
    logic [159:0] win0;
    logic [191:0] win1;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;
    logic [7:0] mem [256];
    int mptr = 0;

    always #4 clk = ~clk;
    assign sda_bus = sda_m & ~drv;

    cfg_i2c_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_drive_low_o(drv), .win0_o(win0), .win1_o(win1)
    );

    function automatic bit in_win(int a);
        return (a >= 8'h08 && a < 8'h1C) || (a >= 8'h40 && a < 8'h58);
    endfunction

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R4 R9: parallel windows against the model on every clock
    always @(negedge clk) begin
        if (cmp_en) begin
            bit bad = 1'b0;
            int ba = 0, be = 0, bx = 0;
            for (int i = 0; i < 20; i++)
                if (win0[i*8 +: 8] !== mem[8'h08 + i] && !bad) begin
                    bad = 1'b1; ba = win0[i*8 +: 8]; be = mem[8'h08 + i]; bx = 8'h08 + i;
                end
            for (int i = 0; i < 24; i++)
                if (win1[i*8 +: 8] !== mem[8'h40 + i] && !bad) begin
                    bad = 1'b1; ba = win1[i*8 +: 8]; be = mem[8'h40 + i]; bx = 8'h40 + i;
                end
            n_chk++;
            if (bad) begin
                n_fail++;
                $display("FAIL R4 R9 window byte %0h actual=%0h expected=%0h", bx, ba, be);
            end
        end
    end

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b0; wait_clk(HALF);
        scl_m = 1'b0; wait_clk(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b1; wait_clk(HALF);
    endtask

    // Send one byte; a data byte updates the model before the ACK pulse rises.
    task automatic send_byte(input logic [7:0] b, input bit is_data, output bit ack);
        if (is_data) cmp_en = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_clk(HALF);
            scl_m = 1'b1; wait_clk(HALF);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wait_clk(HALF);
        if (is_data) begin
            if (in_win(mptr)) mem[mptr] = b;
            mptr = (mptr + 1) % 256;
            cmp_en = 1'b1;
        end
        scl_m = 1'b1; wait_clk(HALF / 2);
        ack = sda_bus;
        wait_clk(HALF - HALF / 2);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            wait_clk(HALF);
            scl_m = 1'b1; wait_clk(HALF / 2);
            b = {b[6:0], sda_bus};
            wait_clk(HALF - HALF / 2);
            scl_m = 1'b0;
        end
        sda_m = !mack; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF);
        scl_m = 1'b0; wait_clk(1);
        sda_m = 1'b1;
    endtask

    task automatic write_burst(input logic [7:0] a, input logic [7:0] d0,
                               input logic [7:0] d1, input logic [7:0] d2, input int n);
        bit ack;
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b0, ack); chk(ack == 1'b0, "R1 R2 device ack", ack, 0);
        send_byte(a, 1'b0, ack);           chk(ack == 1'b0, "R2 register ack", ack, 0);
        mptr = a;
        for (int k = 0; k < n; k++) begin
            send_byte(d[k], 1'b1, ack);
            chk(ack == 1'b0, "R3 R9 data ack", ack, 0);
        end
        bus_stop();
    endtask

    // Read n bytes, ACK all but the last; then check SDA stays released (R7).
    task automatic read_n(input int n, input string tag);
        logic [7:0] b;
        int exp;
        for (int k = 0; k < n; k++) begin
            exp = mem[mptr];
            recv_byte(k != n - 1, b);
            mptr = (mptr + 1) % 256;
            chk(b == exp, tag, b, exp);
        end
        wait_clk(HALF);
        chk(drv == 1'b0, "R7 released after NACK", drv, 0);
        bus_stop();
    endtask

    task automatic read_at(input logic [7:0] a, input int n, input string tag);
        bit ack;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b0, ack); chk(ack == 1'b0, "R2 device ack", ack, 0);
        send_byte(a, 1'b0, ack);           chk(ack == 1'b0, "R2 register ack", ack, 0);
        mptr = a;
        bus_start();
        send_byte({DEV, 1'b1}, 1'b0, ack); chk(ack == 1'b0, "R6 read ack", ack, 0);
        read_n(n, tag);
    endtask

    task automatic read_cur(input int n, input string tag);
        bit ack;
        bus_start();
        send_byte({DEV, 1'b1}, 1'b0, ack); chk(ack == 1'b0, "R5 read ack", ack, 0);
        read_n(n, tag);
    endtask

    // Watchdog: a hung run is one failed check and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R11 watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit ack;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R10: blank state and released bus
        chk(drv == 1'b0, "R10 SDA released", drv, 0);
        chk(win0 == '0 && win1 == '0, "R10 blank registers", int'(win0[31:0]), 0);
        cmp_en = 1'b1;

        // R3 R4: burst at the start of the first window
        write_burst(8'h08, 8'hA1, 8'hB2, 8'hC3, 3);

        // R1: foreign address is not acknowledged and writes nothing
        bus_start();
        send_byte({7'h22, 1'b0}, 1'b0, ack); chk(ack == 1'b1, "R1 foreign address NACK", ack, 1);
        send_byte(8'h08, 1'b0, ack);         chk(ack == 1'b1, "R1 no ack after miss", ack, 1);
        send_byte(8'h77, 1'b0, ack);         chk(ack == 1'b1, "R1 no ack after miss", ack, 1);
        bus_stop();

        // R6: random read through a repeated START
        read_at(8'h09, 1, "R6 random read");
        // R5: current-address read continues at n+1
        read_cur(1, "R5 current address read");
        // R7: sequential read with master ACKs
        read_at(8'h08, 4, "R7 sequential read");

        // R9: burst across the end of the first window
        write_burst(8'h1A, 8'h5A, 8'h6B, 8'h7C, 3);
        read_at(8'h1C, 1, "R9 unbacked location reads zero");
        // R9: both edges of the second window
        write_burst(8'h3F, 8'h11, 8'h22, 8'h00, 2);
        write_burst(8'h57, 8'h99, 8'h88, 8'h00, 2);
        read_at(8'h56, 3, "R9 second window edges");

        // R8: write burst crossing FFH, then read across the wrap
        write_burst(8'hFE, 8'h31, 8'h32, 8'h33, 3);
        read_at(8'hFF, 11, "R8 read across wrap");
        read_cur(1, "R5 pointer kept across transactions");

        // R11: STOP inside a data byte discards it
        bus_start();
        send_byte({DEV, 1'b0}, 1'b0, ack);
        send_byte(8'h10, 1'b0, ack);
        mptr = 8'h10;
        for (int i = 0; i < 4; i++) begin
            sda_m = 1'b1; wait_clk(HALF);
            scl_m = 1'b1; wait_clk(HALF);
            scl_m = 1'b0;
        end
        bus_stop();
        read_cur(1, "R11 aborted byte not stored");

        wait_clk(20);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule